// File: doc/BRIEF.md
# Subaddress Data Buffer Address Manager

This block generates the RAM word addresses that a remote-terminal protocol engine uses to store received data words and to fetch transmit data words for one subaddress. It holds three descriptor tables: receive, transmit and broadcast-receive. Each table has one entry per subaddress. An entry names a data block base address and a storage mode. In single-block mode every message reuses the same block. In circular mode the entry keeps a running pointer inside a power-of-two buffer, and that pointer is advanced and wrapped message after message.

The protocol engine pulses `msg_start` with the direction, broadcast flag, subaddress and word count of a message. It then pulses `word_adv` once for each data word moved and closes the message with `msg_end`, flagging any error on `msg_err`. The block drives the current word address and raises one-cycle end-of-message and buffer-boundary interrupt events. Software-side configuration comes in through a single write port that loads one table entry per cycle.

Top module: `sabuf_addr_mgr`

## Requirements
- R1: After reset every table entry is single-block mode with base 0, pointer 0 and per-entry interrupt disabled, and `addr_valid`, `word_addr`, `eom_irq` and `bnd_irq` are all 0.
- R2: A message takes its entry from the transmit table (`cfg_tbl`=1) when `msg_tx`=1. It takes its entry from the broadcast table (`cfg_tbl`=2) when it is a broadcast receive and `bcast_sep`=1. Otherwise it uses the receive table (`cfg_tbl`=0).
- R3: A configuration write loads base, mode (`cfg_circ`=1 means circular), size code and per-entry interrupt enable, and resets the entry's pointer. In circular mode the pointer is reset to the base with its low log2(size) bits cleared. A configuration write wins over a pointer write-back to the same entry in the same cycle.
- R4: In single-block mode, `word_addr` equals the entry base in the cycle after `msg_start` and rises by 1 for each accepted `word_adv`. The stored pointer is never changed by a message.
- R5: In circular mode, a message starts at the stored pointer. The buffer size is 128 << code for size codes 0 to 6, and code 7 is treated as 6. Each accepted `word_adv` increments the low log2(size) address bits and keeps the upper bits, so the address wraps from the buffer top back to its aligned base.
- R6: In circular mode the final address is written back as the entry's pointer only when `msg_end` arrives with `msg_err`=0. A message that ends in error leaves the pointer unchanged.
- R7: `msg_wc` gives the number of data words (1 to 31, with 0 meaning 32). `word_adv` pulses beyond that count leave `word_addr` unchanged.
- R8: `eom_irq` is high for exactly the one cycle after an active message's `msg_end` when `eom_all_en`=1, or when `eom_err_en`=1 and `msg_err`=1, or when the entry's interrupt enable is set.
- R9: `bnd_irq` is high for exactly the one cycle after an error-free `msg_end` of a circular message whose address wrapped from the buffer top to its base during that message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_tbl | input | 2 | Table select: 0 receive, 1 transmit, 2 broadcast |
| cfg_sa | input | 5 | Subaddress of the entry written |
| cfg_base | input | 16 | Data block base address |
| cfg_circ | input | 1 | 1 = circular buffer, 0 = single block |
| cfg_code | input | 3 | Circular size code, size = 128 << code |
| cfg_eom_ie | input | 1 | Per-entry end-of-message interrupt enable |
| bcast_sep | input | 1 | Route broadcast receive data to the broadcast table |
| eom_all_en | input | 1 | End-of-message interrupt for every message |
| eom_err_en | input | 1 | End-of-message interrupt for errored messages |
| msg_start | input | 1 | Message start strobe |
| msg_tx | input | 1 | Message is a transmit |
| msg_bcast | input | 1 | Message is a broadcast |
| msg_sa | input | 5 | Message subaddress |
| msg_wc | input | 5 | Data word count, 0 means 32 |
| word_adv | input | 1 | One data word moved, advance the address |
| msg_end | input | 1 | Message end strobe |
| msg_err | input | 1 | Message ended with an error |
| addr_valid | output | 1 | A message is in progress |
| word_addr | output | 16 | Current data word RAM address |
| eom_irq | output | 1 | End-of-message interrupt event |
| bnd_irq | output | 1 | Circular buffer boundary interrupt event |

## Verification
The bench drives the circular pointer across the top of a 128-word buffer. A design that carries into the upper address bits there would leave the buffer and never raise the boundary event. Errored messages are followed by a fresh message on the same subaddress, which catches a design that writes the pointer back anyway and so starts the next message in the wrong place. Surplus word strobes beyond the count show whether the address creeps past the message length. Broadcast receives with separation on and off show whether the design picks the wrong table, which would show up as the wrong start address. Single-block messages repeated on one subaddress expose any design that advances the stored pointer in that mode.

// File: rtl/sabuf_pkg.sv
package sabuf_pkg;

    typedef enum logic [1:0] {
        TBL_RX = 2'd0,
        TBL_TX = 2'd1,
        TBL_BC = 2'd2
    } tbl_e;

    localparam int MIN_LOG2  = 7;
    localparam int MAX_CODE  = 6;
    localparam int CODE_W    = 3;

    // Mask of the in-buffer offset bits for a size code (code 7 clamps to 6).
    function automatic logic [31:0] size_mask(input logic [CODE_W-1:0] code);
        logic [CODE_W-1:0] c;
        int                lg;
        c  = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        lg = MIN_LOG2 + int'(c);
        return (32'd1 << lg) - 32'd1;
    endfunction

endpackage

// File: rtl/sabuf_wrap.sv
module sabuf_wrap
    import sabuf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] ptr,
    input  logic              circ,
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] nxt,
    output logic              at_top
);
    logic [31:0]       mask32;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] inc;

    always_comb begin
        mask32 = size_mask(code);
        mask   = mask32[ADDR_W-1:0];
        inc    = ptr + ADDR_W'(1);
        nxt    = circ ? ((ptr & ~mask) | (inc & mask)) : inc;
        at_top = circ && ((ptr & mask) == mask);
    end
endmodule

// File: rtl/sabuf_table.sv
module sabuf_table
    import sabuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SA_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    // configuration write port
    input  logic              cfg_we,
    input  logic [1:0]        cfg_tbl,
    input  logic [SA_W-1:0]   cfg_sa,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_circ,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              cfg_ie,
    // pointer write-back port
    input  logic              wb_en,
    input  logic [1:0]        wb_tbl,
    input  logic [SA_W-1:0]   wb_sa,
    input  logic [ADDR_W-1:0] wb_ptr,
    // read port
    input  logic [1:0]        rd_tbl,
    input  logic [SA_W-1:0]   rd_sa,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              rd_circ,
    output logic [CODE_W-1:0] rd_code,
    output logic              rd_ie
);
    localparam int IDX_W = 2 + SA_W;
    localparam int DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] base_q [DEPTH];
    logic [ADDR_W-1:0] ptr_q  [DEPTH];
    logic              circ_q [DEPTH];
    logic [CODE_W-1:0] code_q [DEPTH];
    logic              ie_q   [DEPTH];

    logic [IDX_W-1:0]  cfg_idx, wb_idx, rd_idx;
    logic [31:0]       cfg_mask32;
    logic [ADDR_W-1:0] cfg_ptr_d;

    always_comb begin
        cfg_idx    = {cfg_tbl, cfg_sa};
        wb_idx     = {wb_tbl, wb_sa};
        rd_idx     = {rd_tbl, rd_sa};
        cfg_mask32 = size_mask(cfg_code);
        cfg_ptr_d  = cfg_circ ? (cfg_base & ~cfg_mask32[ADDR_W-1:0]) : cfg_base;
        rd_base    = base_q[rd_idx];
        rd_ptr     = ptr_q[rd_idx];
        rd_circ    = circ_q[rd_idx];
        rd_code    = code_q[rd_idx];
        rd_ie      = ie_q[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                base_q[i] <= '0;
                ptr_q[i]  <= '0;
                circ_q[i] <= 1'b0;
                code_q[i] <= '0;
                ie_q[i]   <= 1'b0;
            end
        end else begin
            if (wb_en && !(cfg_we && cfg_idx == wb_idx)) begin
                ptr_q[wb_idx] <= wb_ptr;
            end
            if (cfg_we) begin
                base_q[cfg_idx] <= cfg_base;
                ptr_q[cfg_idx]  <= cfg_ptr_d;
                circ_q[cfg_idx] <= cfg_circ;
                code_q[cfg_idx] <= cfg_code;
                ie_q[cfg_idx]   <= cfg_ie;
            end
        end
    end

    // R6: a write-back only ever targets a circular entry
    a_r6_wb_circular_only: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> circ_q[wb_idx]);
endmodule

// File: rtl/sabuf_addr_mgr.sv
module sabuf_addr_mgr
    import sabuf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SA_W   = 5,
    parameter int WC_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_tbl,
    input  logic [SA_W-1:0]   cfg_sa,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              cfg_circ,
    input  logic [2:0]        cfg_code,
    input  logic              cfg_eom_ie,
    input  logic              bcast_sep,
    input  logic              eom_all_en,
    input  logic              eom_err_en,
    input  logic              msg_start,
    input  logic              msg_tx,
    input  logic              msg_bcast,
    input  logic [SA_W-1:0]   msg_sa,
    input  logic [WC_W-1:0]   msg_wc,
    input  logic              word_adv,
    input  logic              msg_end,
    input  logic              msg_err,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] word_addr,
    output logic              eom_irq,
    output logic              bnd_irq
);
    localparam int LEFT_W  = WC_W + 1;
    localparam int MAX_WDS = 1 << WC_W;

    typedef struct packed {
        logic              active;
        logic [1:0]        tbl;
        logic [SA_W-1:0]   sa;
        logic              circ;
        logic [CODE_W-1:0] code;
        logic              ie;
        logic [ADDR_W-1:0] ptr;
        logic [LEFT_W-1:0] left;
        logic              wrapped;
        logic              eom;
        logic              bnd;
    } st_t;

    st_t st_d, st_q;

    tbl_e              sel_tbl;
    logic [ADDR_W-1:0] rd_base, rd_ptr, nxt_ptr;
    logic              rd_circ, rd_ie, at_top, wb_en;
    logic [CODE_W-1:0] rd_code;
    logic [31:0]       act_mask32;

    always_comb begin
        if (msg_tx)                      sel_tbl = TBL_TX;
        else if (msg_bcast && bcast_sep) sel_tbl = TBL_BC;
        else                             sel_tbl = TBL_RX;
    end

    sabuf_table #(.ADDR_W(ADDR_W), .SA_W(SA_W)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_tbl  (cfg_tbl),
        .cfg_sa   (cfg_sa),
        .cfg_base (cfg_base),
        .cfg_circ (cfg_circ),
        .cfg_code (cfg_code),
        .cfg_ie   (cfg_eom_ie),
        .wb_en    (wb_en),
        .wb_tbl   (st_q.tbl),
        .wb_sa    (st_q.sa),
        .wb_ptr   (st_q.ptr),
        .rd_tbl   (sel_tbl),
        .rd_sa    (msg_sa),
        .rd_base  (rd_base),
        .rd_ptr   (rd_ptr),
        .rd_circ  (rd_circ),
        .rd_code  (rd_code),
        .rd_ie    (rd_ie)
    );

    sabuf_wrap #(.ADDR_W(ADDR_W)) i_wrap (
        .ptr    (st_q.ptr),
        .circ   (st_q.circ),
        .code   (st_q.code),
        .nxt    (nxt_ptr),
        .at_top (at_top)
    );

    always_comb begin
        st_d     = st_q;
        st_d.eom = 1'b0;
        st_d.bnd = 1'b0;
        wb_en    = 1'b0;
        if (msg_start) begin
            st_d.active  = 1'b1;
            st_d.tbl     = sel_tbl;
            st_d.sa      = msg_sa;
            st_d.circ    = rd_circ;
            st_d.code    = rd_code;
            st_d.ie      = rd_ie;
            st_d.ptr     = rd_circ ? rd_ptr : rd_base;
            st_d.left    = (msg_wc == '0) ? LEFT_W'(MAX_WDS) : {1'b0, msg_wc};
            st_d.wrapped = 1'b0;
        end else if (st_q.active && msg_end) begin
            st_d.active = 1'b0;
            st_d.eom    = eom_all_en | (eom_err_en & msg_err) | st_q.ie;
            st_d.bnd    = st_q.circ & ~msg_err & st_q.wrapped;
            wb_en       = st_q.circ & ~msg_err;
        end else if (st_q.active && word_adv && st_q.left != '0) begin
            st_d.ptr  = nxt_ptr;
            st_d.left = st_q.left - LEFT_W'(1);
            if (at_top) st_d.wrapped = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_valid = st_q.active;
    assign word_addr  = st_q.ptr;
    assign eom_irq    = st_q.eom;
    assign bnd_irq    = st_q.bnd;
    assign act_mask32 = size_mask(st_q.code);

    // R5: within a circular message the address never leaves its buffer
    a_r5_stay_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.circ && !msg_start && !msg_end) |=>
        (((word_addr ^ $past(word_addr)) & ~act_mask32[ADDR_W-1:0]) == '0));

    // R4: single-block mode moves one word per accepted strobe
    a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_q.circ && word_adv && st_q.left != '0 && !msg_start && !msg_end)
        |=> word_addr == $past(word_addr) + ADDR_W'(1));

    // R7: strobes past the word count leave the address alone
    a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.left == '0 && !msg_start && !msg_end) |=> $stable(word_addr));

    // R8: an end-of-message event follows only a message end
    a_r8_eom_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!(st_q.active && msg_end) || msg_start) |=> !eom_irq);

    // R9: a boundary event needs an error-free end
    a_r9_bnd_needs_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!(st_q.active && msg_end && !msg_err) || msg_start) |=> !bnd_irq);
endmodule

// File: tb/test_sabuf_addr_mgr.sv
module test_sabuf_addr_mgr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_circ, cfg_eom_ie;
    logic [1:0]  cfg_tbl;
    logic [4:0]  cfg_sa, msg_sa, msg_wc;
    logic [15:0] cfg_base;
    logic [2:0]  cfg_code;
    logic        bcast_sep, eom_all_en, eom_err_en;
    logic        msg_start, msg_tx, msg_bcast, word_adv, msg_end, msg_err;
    logic        addr_valid, eom_irq, bnd_irq;
    logic [15:0] word_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // model of the tables, indexed [table][sa]
    logic [15:0] m_base [4][32];
    logic [15:0] m_ptr  [4][32];
    logic        m_circ [4][32];
    logic [2:0]  m_code [4][32];
    logic        m_ie   [4][32];

    always #(CLK_PERIOD/2) clk = ~clk;

    sabuf_addr_mgr i_sabuf_addr_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_sa(cfg_sa),
        .cfg_base(cfg_base), .cfg_circ(cfg_circ), .cfg_code(cfg_code), .cfg_eom_ie(cfg_eom_ie),
        .bcast_sep(bcast_sep), .eom_all_en(eom_all_en), .eom_err_en(eom_err_en),
        .msg_start(msg_start), .msg_tx(msg_tx), .msg_bcast(msg_bcast), .msg_sa(msg_sa),
        .msg_wc(msg_wc), .word_adv(word_adv), .msg_end(msg_end), .msg_err(msg_err),
        .addr_valid(addr_valid), .word_addr(word_addr), .eom_irq(eom_irq), .bnd_irq(bnd_irq)
    );

    function automatic logic [15:0] f_mask(input logic [2:0] code);
        int c = (code > 3'd6) ? 6 : int'(code);
        return 16'((32'd1 << (7 + c)) - 1);
    endfunction

    function automatic logic [15:0] f_next(input logic [15:0] p, input logic circ,
                                           input logic [2:0] code);
        logic [15:0] m = f_mask(code);
        if (!circ) return p + 16'd1;
        return (p & ~m) | ((p + 16'd1) & m);
    endfunction

    function automatic int f_tbl(input logic tx, input logic bc, input logic sep);
        if (tx) return 1;
        if (bc && sep) return 2;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cfg_we = 0; msg_start = 0; word_adv = 0; msg_end = 0; msg_err = 0;
    endtask

    task automatic write_cfg(input int tbl, input int sa, input logic [15:0] base,
                             input logic circ, input logic [2:0] code, input logic ie);
        cfg_we = 1; cfg_tbl = 2'(tbl); cfg_sa = 5'(sa); cfg_base = base;
        cfg_circ = circ; cfg_code = code; cfg_eom_ie = ie;
        tick();
        cfg_we = 0;
        m_base[tbl][sa] = base;
        m_circ[tbl][sa] = circ;
        m_code[tbl][sa] = code;
        m_ie[tbl][sa]   = ie;
        m_ptr[tbl][sa]  = circ ? (base & ~f_mask(code)) : base;
    endtask

    // Runs one message and checks the address stream and the end events.
    task automatic run_msg(input logic tx, input logic bc, input int sa, input int wc,
                           input int nadv, input logic err);
        int          t = f_tbl(tx, bc, bcast_sep);
        logic [15:0] exp_addr;
        int          left;
        bit          wrapped = 0;
        bit          exp_eom, exp_bnd;
        logic [15:0] m;
        msg_start = 1; msg_tx = tx; msg_bcast = bc; msg_sa = 5'(sa); msg_wc = 5'(wc);
        tick();
        msg_start = 0;
        exp_addr = m_circ[t][sa] ? m_ptr[t][sa] : m_base[t][sa];
        check(word_addr == exp_addr && addr_valid,
              m_circ[t][sa] ? "R5/R2 start address" : "R4/R2 start address",
              int'(word_addr), int'(exp_addr));
        left = (wc == 0) ? 32 : wc;
        m = f_mask(m_code[t][sa]);
        for (int i = 0; i < nadv; i++) begin
            word_adv = 1;
            tick();
            word_adv = 0;
            if (left > 0) begin
                if (m_circ[t][sa] && ((exp_addr & m) == m)) wrapped = 1;
                exp_addr = f_next(exp_addr, m_circ[t][sa], m_code[t][sa]);
                left--;
                check(word_addr == exp_addr, m_circ[t][sa] ? "R5 advance" : "R4 advance",
                      int'(word_addr), int'(exp_addr));
            end else begin
                check(word_addr == exp_addr, "R7 surplus strobe ignored",
                      int'(word_addr), int'(exp_addr));
            end
        end
        msg_end = 1; msg_err = err;
        tick();
        msg_end = 0; msg_err = 0;
        exp_eom = eom_all_en || (eom_err_en && err) || m_ie[t][sa];
        exp_bnd = m_circ[t][sa] && !err && wrapped;
        check(eom_irq == exp_eom, "R8 eom event", int'(eom_irq), int'(exp_eom));
        check(bnd_irq == exp_bnd, "R9 boundary event", int'(bnd_irq), int'(exp_bnd));
        check(!addr_valid, "R8 message closed", int'(addr_valid), 0);
        if (m_circ[t][sa] && !err) m_ptr[t][sa] = exp_addr;
        tick();
        check(!eom_irq && !bnd_irq, "R8 R9 single-cycle events",
              int'({eom_irq, bnd_irq}), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed = 1234;
        void'($urandom(seed));
        for (int t = 0; t < 4; t++)
            for (int s = 0; s < 32; s++) begin
                m_base[t][s] = 0; m_ptr[t][s] = 0; m_circ[t][s] = 0;
                m_code[t][s] = 0; m_ie[t][s] = 0;
            end
        rst_n = 0; idle_inputs();
        cfg_tbl = 0; cfg_sa = 0; cfg_base = 0; cfg_circ = 0; cfg_code = 0; cfg_eom_ie = 0;
        bcast_sep = 0; eom_all_en = 0; eom_err_en = 0;
        msg_tx = 0; msg_bcast = 0; msg_sa = 0; msg_wc = 0;
        tick(); tick();
        rst_n = 1;
        tick();
        // R1: reset state
        check(!addr_valid && word_addr == 0 && !eom_irq && !bnd_irq, "R1 reset outputs",
              int'({addr_valid, eom_irq, bnd_irq}), 0);
        run_msg(0, 0, 9, 4, 4, 0); // R1: untouched entry starts at 0, no event

        // R2: three tables with distinct bases on one subaddress
        write_cfg(0, 3, 16'h1000, 0, 0, 0);
        write_cfg(1, 3, 16'h2000, 0, 0, 1);
        write_cfg(2, 3, 16'h3000, 0, 0, 0);
        run_msg(1, 0, 3, 5, 5, 0);
        run_msg(0, 0, 3, 5, 5, 0);
        run_msg(0, 1, 3, 5, 5, 0);   // separation off: receive table
        bcast_sep = 1;
        run_msg(0, 1, 3, 5, 5, 0);   // separation on: broadcast table
        // R4: single block restarts at base every message
        run_msg(0, 1, 3, 3, 3, 0);

        // R3 R5 R6 R9: circular 128-word buffer, unaligned base gets aligned
        write_cfg(0, 5, 16'h0437, 1, 0, 0);
        run_msg(0, 0, 5, 0, 32, 0);
        run_msg(0, 0, 5, 0, 32, 0);
        run_msg(0, 0, 5, 0, 32, 1);  // R6: errored, pointer kept
        run_msg(0, 0, 5, 0, 32, 0);
        run_msg(0, 0, 5, 0, 32, 0);  // wraps: R9 boundary event
        run_msg(0, 0, 5, 10, 14, 0); // R7: surplus strobes
        // R8: global and error-only enables
        eom_err_en = 1;
        run_msg(0, 0, 5, 2, 2, 1);
        run_msg(0, 0, 5, 2, 2, 0);
        eom_all_en = 1;
        run_msg(0, 0, 5, 2, 2, 0);
        eom_all_en = 0; eom_err_en = 0;
        // R5: code 7 clamps to the 8192-word buffer
        write_cfg(1, 6, 16'h7FF0, 1, 7, 1);
        run_msg(1, 0, 6, 8, 8, 0);

        // R3: config write and write-back in the same cycle, config wins
        write_cfg(0, 7, 16'h0500, 1, 0, 0);
        msg_start = 1; msg_tx = 0; msg_bcast = 0; msg_sa = 7; msg_wc = 3;
        tick(); msg_start = 0;
        word_adv = 1; tick(); tick(); word_adv = 0;
        msg_end = 1; cfg_we = 1; cfg_tbl = 0; cfg_sa = 7; cfg_base = 16'h0600;
        cfg_circ = 1; cfg_code = 0; cfg_eom_ie = 0;
        tick(); idle_inputs();
        m_base[0][7] = 16'h0600; m_ptr[0][7] = 16'h0600;
        run_msg(0, 0, 7, 1, 1, 0);

        // random traffic over a few subaddresses
        for (int n = 0; n < 400; n++) begin
            if (($urandom() % 8) == 0)
                write_cfg(int'($urandom() % 3), int'($urandom() % 4),
                          16'($urandom()), 1'($urandom()), 3'($urandom()), 1'($urandom()));
            bcast_sep  = 1'($urandom());
            eom_all_en = (($urandom() % 4) == 0);
            eom_err_en = 1'($urandom());
            begin
                int wc = int'($urandom() % 32);
                int nw = (wc == 0) ? 32 : wc;
                run_msg(1'($urandom()), 1'($urandom()), int'($urandom() % 4), wc,
                        nw + int'($urandom() % 3) - 1 + ((nw == 1) ? 1 : 0),
                        (($urandom() % 5) == 0));
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule